// File: doc/BRIEF.md
# Binary to Decimal Digit Converter with Leading-Zero Blanking

The block turns an unsigned binary word into a fixed row of decimal digit codes for a numeric display. Digit position 0 is the least significant. Each position carries a 5-bit code. The low four bits give the digit value, and bit 4 marks a position the display should leave dark.

A one-cycle start strobe latches the binary value and a mode input. The mode chooses between printing leading zeros and blanking them. The conversion runs one input bit per clock using shift-and-add-3 correction. When it finishes, all digit codes update together and a done strobe fires for one cycle. The codes then hold until the next conversion completes. While a conversion is running, further start strobes are dropped. A value too wide for the digit row keeps only its low decimal digits.

Top module: `bin2bcd_blank`

## Requirements
- R1: After reset, busy_o and done_o are 0 and every digit code on digits_o is 5'h00.
- R2: A start_i pulse seen while busy_o is 0 is accepted: busy_o is 1 in the next cycle. value_i and keep_zeros_i are captured on that edge, and later changes to them do not affect the result.
- R3: done_o is high for exactly one cycle. It rises BIN_W+1 clock edges after the accepting edge (33 by default), and busy_o falls in the same cycle.
- R4: Digit i occupies digits_o[5i+4:5i], with i=0 the least significant. A shown digit is {1'b0, value 0..9}, and a blank position is exactly 5'h10.
- R5: With keep_zeros_i=1, all NDIG positions show plain decimal digits, so leading zeros appear as 5'h00.
- R6: With keep_zeros_i=0, every position above the most significant nonzero digit reads 5'h10, and all positions at or below it show their digit.
- R7: A value of zero gives all positions 5'h10 in blanking mode, including position 0, and all positions 5'h00 in keep mode.
- R8: A start_i pulse while busy_o is 1 is ignored. The running conversion finishes with its own value and produces exactly one done_o pulse.
- R9: digits_o changes only in a cycle where done_o is 1, and it otherwise holds its last value.
- R10: A value above 10^NDIG-1 converts as value modulo 10^NDIG (for example, 4294967295 shows 94967295).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to convert value_i |
| value_i | input | BIN_W | Unsigned binary value to convert |
| keep_zeros_i | input | 1 | 1: show leading zeros, 0: blank them |
| busy_o | output | 1 | Conversion in progress, start_i ignored |
| done_o | output | 1 | One-cycle pulse when new codes are on digits_o |
| digits_o | output | 5*NDIG | Digit codes, position 0 in the low five bits |

## Verification
The hardest case to reach from the ports is a second start strobe landing partway through a conversion, combined with input changes right after the accepting edge. The stimulus fires a stray start carrying a different value and mode in the middle of a run. It also scrambles value_i and keep_zeros_i on every cycle after acceptance. The scoreboard then demands a single done pulse that carries the first request's digits. The boundary values are zero in both modes, 99999999, 100000000 and the all-ones word, so the wrap and the blanking edge are both exercised.

// File: rtl/bin2bcd_blank_pkg.sv
package bin2bcd_blank_pkg;
  localparam int CODE_W = 5;
  typedef logic [CODE_W-1:0] digit_code_t;
  localparam digit_code_t BLANK_CODE = 5'h10;
endpackage

// File: rtl/bcd_add3_cell.sv
module bcd_add3_cell (
  input  logic [3:0] nib_i,
  output logic [3:0] nib_o
);
  // correct a BCD nibble before doubling so the carry lands in the next digit
  always_comb nib_o = (nib_i >= 4'd5) ? nib_i + 4'd3 : nib_i;
endmodule

// File: rtl/bcd_shift_core.sv
module bcd_shift_core #(
  parameter int BIN_W = 32,
  parameter int NDIG  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [BIN_W-1:0]   value_i,
  output logic               busy_o,
  output logic               fin_o,
  output logic [4*NDIG-1:0]  bcd_o
);
  localparam int BCD_W = 4 * NDIG;
  localparam int CNT_W = (BIN_W > 1) ? $clog2(BIN_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIN_W - 1);

  logic [BIN_W-1:0] sreg_q;
  logic [BCD_W-1:0] bcd_q, adj;
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NDIG; g++) begin : g_adj
    bcd_add3_cell u_cell (.nib_i(bcd_q[4*g +: 4]), .nib_o(adj[4*g +: 4]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      bcd_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      fin_o  <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (load_i) begin
        sreg_q <= value_i;
        bcd_q  <= '0;
        cnt_q  <= '0;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        // top digit carry drops out: the result is value mod 10^NDIG
        bcd_q  <= {adj[BCD_W-2:0], sreg_q[BIN_W-1]};
        sreg_q <= sreg_q << 1;
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_o <= 1'b0;
          fin_o  <= 1'b1;
        end
      end
    end
  end

  assign bcd_o = bcd_q;
endmodule

// File: rtl/digit_blanker.sv
module digit_blanker
  import bin2bcd_blank_pkg::*;
#(
  parameter int NDIG = 8
) (
  input  logic                   keep_zeros_i,
  input  logic [4*NDIG-1:0]      bcd_i,
  output logic [CODE_W*NDIG-1:0] codes_o
);
  // lit[i]: some digit at position i or higher is nonzero
  logic [NDIG:0] lit;
  assign lit[NDIG] = 1'b0;

  for (genvar g = 0; g < NDIG; g++) begin : g_pos
    logic [3:0] nib;
    assign nib      = bcd_i[4*g +: 4];
    assign lit[g]   = lit[g+1] | (nib != 4'd0);
    assign codes_o[CODE_W*g +: CODE_W] =
      (!keep_zeros_i && !lit[g]) ? BLANK_CODE : {1'b0, nib};
  end
endmodule

// File: rtl/bin2bcd_blank.sv
module bin2bcd_blank
  import bin2bcd_blank_pkg::*;
#(
  parameter int BIN_W = 32,
  parameter int NDIG  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [BIN_W-1:0]       value_i,
  input  logic                   keep_zeros_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [CODE_W*NDIG-1:0] digits_o
);
  localparam int OUT_W = CODE_W * NDIG;

  logic              core_busy, core_fin, accept, keep_q;
  logic [4*NDIG-1:0] bcd;
  logic [OUT_W-1:0]  codes;

  assign busy_o = core_busy | core_fin;
  assign accept = start_i & ~busy_o;

  bcd_shift_core #(.BIN_W(BIN_W), .NDIG(NDIG)) u_core (
    .clk(clk), .rst(rst), .load_i(accept), .value_i(value_i),
    .busy_o(core_busy), .fin_o(core_fin), .bcd_o(bcd)
  );

  digit_blanker #(.NDIG(NDIG)) u_blank (
    .keep_zeros_i(keep_q), .bcd_i(bcd), .codes_o(codes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      keep_q   <= 1'b0;
      done_o   <= 1'b0;
      digits_o <= '0;
    end else begin
      done_o <= core_fin;
      if (accept) keep_q <= keep_zeros_i;
      if (core_fin) digits_o <= codes;
    end
  end
endmodule

// File: rtl/bin2bcd_blank_chk.sv
module bin2bcd_blank_chk #(
  parameter int BIN_W = 32,
  parameter int NDIG  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [5*NDIG-1:0] digits_o
);
  localparam int LAT = BIN_W + 1;
  localparam int LW  = $clog2(LAT + 2) + 1;

  logic [LW-1:0] lat_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
      run_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      lat_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      lat_q <= lat_q + 1'b1;
      if (done_o) run_q <= 1'b0;
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst) (start_i && !busy_o) |=> busy_o); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst) done_o |-> (run_q && lat_q == LW'(LAT))); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done_o |-> !busy_o); // R3
  AST_STRAY_START: assert property (@(posedge clk) disable iff (rst) (start_i && busy_o && run_q) |=> run_q); // R8
  AST_DIGITS_HOLD: assert property (@(posedge clk) disable iff (rst) !done_o |-> $stable(digits_o)); // R9

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      (digits_o[5*g +: 5] == 5'h10) || (digits_o[5*g +: 5] <= 5'd9)); // R4
    if (g < NDIG - 1) begin : g_up
      AST_BLANK_UPWARD: assert property (@(posedge clk) disable iff (rst)
        (digits_o[5*g +: 5] == 5'h10) |-> (digits_o[5*(g+1) +: 5] == 5'h10)); // R6
    end
  end
endmodule

bind bin2bcd_blank bin2bcd_blank_chk #(.BIN_W(BIN_W), .NDIG(NDIG)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .digits_o(digits_o)
);

// File: tb/test_bin2bcd_blank.sv
module test_bin2bcd_blank;
  localparam int CLK_PERIOD = 10;
  localparam int BIN_W = 32;
  localparam int NDIG  = 8;
  localparam int OW    = 5 * NDIG;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [BIN_W-1:0] value_i = '0;
  logic             keep_zeros_i = 1'b0;
  logic             busy_o, done_o;
  logic [OW-1:0]    digits_o;

  int checks = 0;
  int fails  = 0;
  int dones  = 0;
  logic [OW-1:0] exp_q[$];
  logic [OW-1:0] last_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bin2bcd_blank #(.BIN_W(BIN_W), .NDIG(NDIG)) i_bin2bcd_blank (
    .clk(clk), .rst(rst), .start_i(start_i), .value_i(value_i),
    .keep_zeros_i(keep_zeros_i), .busy_o(busy_o), .done_o(done_o),
    .digits_o(digits_o)
  );

  function automatic logic [OW-1:0] model(input logic [BIN_W-1:0] v, input logic keep);
    logic [OW-1:0] o = '0;
    longint unsigned rem = longint'(v) % 64'd100000000;
    for (int i = 0; i < NDIG; i++) begin
      if (rem > 0) begin
        o[5*i +: 5] = 5'(rem % 10);
        rem = rem / 10;
      end else begin
        o[5*i +: 5] = keep ? 5'h00 : 5'h10;
      end
    end
    return o;
  endfunction

  task automatic check(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each done pulse
  always @(negedge clk) begin
    if (!rst && done_o) begin
      dones++;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 actual=extra done expected=no done");
      end else begin
        last_exp = exp_q.pop_front();
        check("R4/R5/R6/R7/R10 digits", digits_o, last_exp);
      end
    end
  end

  // driver: stray_at > 0 fires a second start that many cycles into the run
  task automatic convert(input logic [BIN_W-1:0] v, input logic keep, input int stray_at);
    int n = 0;
    int d0 = dones;
    @(negedge clk);
    value_i = v; keep_zeros_i = keep; start_i = 1'b1;
    exp_q.push_back(model(v, keep));
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after accept", OW'(busy_o), OW'(1));
    n = 1;
    while (!done_o && n < 100) begin
      value_i = ~v ^ BIN_W'(n); keep_zeros_i = ~keep;  // R2 scramble after capture
      start_i = (n == stray_at);                        // R8 stray request
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    // done visible at the negedge after the edge BIN_W+1 past acceptance
    check("R3 latency", OW'(n), OW'(BIN_W + 2));
    check("R3 busy low with done", OW'(busy_o), OW'(0));
    repeat (4) @(negedge clk);
    value_i = v + 1;
    @(negedge clk);
    check("R3/R8 single done", OW'(dones - d0), OW'(1));
    check("R9 hold", digits_o, last_exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 busy", OW'(busy_o), OW'(0));
    check("R1 done", OW'(done_o), OW'(0));
    check("R1 digits", digits_o, '0);
    convert(32'd0, 1'b0, 0);            // R7 blank mode
    convert(32'd0, 1'b1, 0);            // R7 keep mode
    convert(32'd7, 1'b0, 0);            // R6
    convert(32'd7, 1'b1, 0);            // R5
    convert(32'd1000, 1'b0, 0);         // R6 inner zeros shown
    convert(32'd12345678, 1'b0, 0);     // R4
    convert(32'd99999999, 1'b0, 0);     // R10 boundary
    convert(32'd100000000, 1'b0, 0);    // R10 wraps to all blank
    convert(32'd100000000, 1'b1, 0);    // R10 wraps to zeros
    convert(32'hFFFFFFFF, 1'b1, 0);     // R10
    convert(32'd40506, 1'b0, 5);        // R8 stray start
    convert(32'd90, 1'b1, 20);          // R8 stray start, keep mode
    convert(32'd1, 1'b0, 31);           // R8 late stray start
    for (int k = 0; k < 6; k++)
      convert(32'(k * 1234567 + 89), k[0], 0);
    check("R8 scoreboard drained", OW'(exp_q.size()), OW'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule